// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Code Latch

This block sits on an 8-bit write-only register bus and holds the 12-bit unsigned codes for two digital-to-analog converter channels. Each channel owns a pair of byte-wide registers. One of them stages the lower eight bits of the code. The other carries the upper four bits. Writing the upper four bits also commits the staged byte, so the parallel code seen by the converter changes in a single step rather than in two halves.

Software writes the lower byte first and the upper nibble second. The latch never checks the order of those writes. If the upper nibble arrives without a fresh lower byte, the committed code combines the new nibble with whatever byte was staged last. That result is intended behaviour and the block reproduces it. Each channel also emits a one-cycle pulse in the first cycle that shows its new code.

Top module: `dac_latch_top`

## Requirements
- R1: After reset, both channel codes read zero, both staging bytes hold zero and neither update pulse is high.
- R2: Offset 4 is the channel 1 lower byte and offset 5 is the channel 1 upper nibble. Offset 6 is the channel 2 lower byte and offset 7 is the channel 2 upper nibble. A write is taken on a rising clock edge when `wrEn` is high.
- R3: A lower-byte write leaves that channel's output code unchanged. It only loads the staging byte.
- R4: An upper-nibble write with data byte d loads the channel code with {d[3:0], staged byte}. The new code is visible after that same clock edge. Bit 11 is the MSB and bit 0 is the LSB.
- R5: Bits 7..4 of an upper-nibble data byte have no effect on the code.
- R6: An upper-nibble write that has no new lower byte before it reuses the lower byte staged last. This also holds when the upper nibble is written repeatedly.
- R7: A channel's update pulse is high for exactly one cycle, and that cycle is the first one that shows the newly loaded code. A lower-byte write produces no pulse.
- R8: Writes to any offset outside 4..7, and any cycle with `wrEn` low, change no code and produce no pulse.
- R9: Writes to one channel never change the other channel's staging byte, code or pulse.
- R10: Writes on consecutive cycles are all accepted, with no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled on the clock edge |
| wrAddr | input | 4 | Register offset of the write |
| wrData | input | 8 | Write data byte |
| ch1Code | output | 12 | Channel 1 code driven to the converter |
| ch2Code | output | 12 | Channel 2 code driven to the converter |
| ch1Update | output | 1 | One-cycle pulse when the channel 1 code has been reloaded |
| ch2Update | output | 1 | One-cycle pulse when the channel 2 code has been reloaded |

## Verification
The hardest situation to reach is a stale combination, because the staging byte cannot be read back and a normal low-then-high pair hides whether it was used at all. The stimulus first commits a known pair. It then writes only the upper nibble, and the expected code must carry the earlier lower byte. It repeats this across a burst of back-to-back writes that alternates between the channels, so a staging byte leaking across channels or a dropped consecutive write shows up in the committed codes.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;
  localparam int DAC_CH = 2;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 12;
  localparam int HI_W   = CODE_W - BYTE_W;

  typedef struct packed {
    logic [DAC_CH-1:0] loadLow;
    logic [DAC_CH-1:0] loadHigh;
  } dacStrobes_t;
endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
  import dac_latch_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BASE_OFS = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output dacStrobes_t       strobes
);
  // Each channel takes two consecutive offsets: lower byte, then upper nibble.
  always_comb begin
    strobes = '0;
    if (wrEn) begin
      for (int c = 0; c < DAC_CH; c++) begin
        if (wrAddr == ADDR_W'(BASE_OFS + 2*c))     strobes.loadLow[c]  = 1'b1;
        if (wrAddr == ADDR_W'(BASE_OFS + 2*c + 1)) strobes.loadHigh[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_hold_path.sv
module dac_hold_path
  import dac_latch_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  dacStrobes_t                   strobes,
  input  logic [BYTE_W-1:0]             wrData,
  output logic [DAC_CH-1:0][CODE_W-1:0] codeOut,
  output logic [DAC_CH-1:0]             updOut
);
  logic [DAC_CH-1:0][BYTE_W-1:0] stageByte;

  for (genvar g = 0; g < DAC_CH; g++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageByte[g] <= '0;
        codeOut[g]   <= '0;
        updOut[g]    <= 1'b0;
      end else begin
        if (strobes.loadLow[g]) stageByte[g] <= wrData;
        // The commit uses the byte staged before this edge, new or stale.
        if (strobes.loadHigh[g]) codeOut[g] <= {wrData[HI_W-1:0], stageByte[g]};
        updOut[g] <= strobes.loadHigh[g];
      end
    end
  end
endmodule

// File: rtl/dac_latch_top.sv
module dac_latch_top
  import dac_latch_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BASE_OFS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic [11:0]       ch1Code,
  output logic [11:0]       ch2Code,
  output logic              ch1Update,
  output logic              ch2Update
);
  dacStrobes_t                   strobes;
  logic [DAC_CH-1:0][CODE_W-1:0] codes;
  logic [DAC_CH-1:0]             upds;

  dac_wr_decode #(.ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS)) u_dec (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .strobes (strobes)
  );

  dac_hold_path u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .codeOut (codes),
    .updOut  (upds)
  );

  assign ch1Code   = codes[0];
  assign ch2Code   = codes[1];
  assign ch1Update = upds[0];
  assign ch2Update = upds[1];
endmodule

// File: rtl/dac_latch_chk.sv
module dac_latch_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [3:0]  wrAddr,
  input logic [3:0]  wrNib,
  input logic [11:0] ch1Code,
  input logic [11:0] ch2Code,
  input logic        ch1Update,
  input logic        ch2Update
);
  logic wr1Lo, wr1Hi, wr2Lo, wr2Hi, wrOther;
  assign wr1Lo   = wrEn && wrAddr == 4'd4;
  assign wr1Hi   = wrEn && wrAddr == 4'd5;
  assign wr2Lo   = wrEn && wrAddr == 4'd6;
  assign wr2Hi   = wrEn && wrAddr == 4'd7;
  assign wrOther = !(wr1Lo || wr1Hi || wr2Lo || wr2Hi);

  AST_LOW_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (wr1Lo || wr2Lo) |=> ($stable(ch1Code) && $stable(ch2Code))); // R3
  AST_HIGH_LOADS_NIB1: assert property (@(posedge clk) disable iff (!rstN)
    wr1Hi |=> (ch1Code[11:8] == $past(wrNib))); // R4
  AST_HIGH_LOADS_NIB2: assert property (@(posedge clk) disable iff (!rstN)
    wr2Hi |=> (ch2Code[11:8] == $past(wrNib))); // R4
  AST_PULSE_SOURCE1: assert property (@(posedge clk) disable iff (!rstN)
    ch1Update |-> $past(wr1Hi)); // R7
  AST_PULSE_SOURCE2: assert property (@(posedge clk) disable iff (!rstN)
    ch2Update |-> $past(wr2Hi)); // R7
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrOther |=> ($stable(ch1Code) && $stable(ch2Code) && !ch1Update && !ch2Update)); // R8
  AST_CH1_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    (wr1Lo || wr1Hi) |=> ($stable(ch2Code) && !ch2Update)); // R9
  AST_CH2_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    (wr2Lo || wr2Hi) |=> ($stable(ch1Code) && !ch1Update)); // R9
endmodule

bind dac_latch_top dac_latch_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrNib     (wrData[3:0]),
  .ch1Code   (ch1Code),
  .ch2Code   (ch2Code),
  .ch1Update (ch1Update),
  .ch2Update (ch2Update)
);

// File: tb/sim_dac_latch_top.sv
`timescale 1ns/1ps
module sim_dac_latch_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [11:0] ch1Code, ch2Code;
  logic        ch1Update, ch2Update;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dac_latch_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ch1Code(ch1Code), .ch2Code(ch2Code), .ch1Update(ch1Update), .ch2Update(ch2Update)
  );

  // Bench model, kept from the requirements alone.
  logic [7:0]  mStage [2];
  logic [11:0] mCode  [2];

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input logic u1, input logic u2);
    check({tag, " ch1Code"}, ch1Code, mCode[0]);
    check({tag, " ch2Code"}, ch2Code, mCode[1]);
    check({tag, " ch1Update"}, {11'd0, ch1Update}, {11'd0, u1});
    check({tag, " ch2Update"}, {11'd0, ch2Update}, {11'd0, u2});
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic doWrite(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a >= 4 && a <= 7) begin
      int ch = (a - 4) / 2;
      if (a[0]) mCode[ch] = {d[3:0], mStage[ch]};
      else mStage[ch] = d;
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic testReset();
    mStage[0] = 0; mStage[1] = 0; mCode[0] = 0; mCode[1] = 0;
    checkAll("R1 reset", 1'b0, 1'b0);
    doWrite(4'd5, 8'h00);          // commits staged byte: must be zero
    check("R1 staged byte zero", ch1Code, 12'h000);
    idle();
  endtask

  task automatic testLowThenHigh();
    doWrite(4'd4, 8'hA5);
    checkAll("R3 R7 low write", 1'b0, 1'b0);
    doWrite(4'd5, 8'hF3);          // upper bits F must be dropped
    check("R4 R5 ch1 commit", ch1Code, 12'h3A5);
    checkAll("R7 pulse on commit", 1'b1, 1'b0);
    idle();
    checkAll("R7 pulse one cycle", 1'b0, 1'b0);
  endtask

  task automatic testStale();
    doWrite(4'd5, 8'h07);
    check("R6 stale low byte", ch1Code, 12'h7A5);
    doWrite(4'd5, 8'h8C);
    check("R6 R5 repeated high", ch1Code, 12'hCA5);
    idle();
  endtask

  task automatic testChannel2();
    doWrite(4'd6, 8'h5C);
    checkAll("R2 R9 ch2 low", 1'b0, 1'b0);
    doWrite(4'd7, 8'h09);
    check("R2 ch2 commit", ch2Code, 12'h95C);
    checkAll("R9 ch1 untouched", 1'b0, 1'b1);
    doWrite(4'd5, 8'h01);          // ch1 must still use its own staged A5
    check("R9 ch1 stage isolated", ch1Code, 12'h1A5);
    idle();
  endtask

  task automatic testUnrelated();
    doWrite(4'd0, 8'hFF); checkAll("R8 offset 0", 1'b0, 1'b0);
    doWrite(4'd3, 8'hFF); checkAll("R8 offset 3", 1'b0, 1'b0);
    doWrite(4'd8, 8'hFF); checkAll("R8 offset 8", 1'b0, 1'b0);
    doWrite(4'd15, 8'hFF); checkAll("R8 offset 15", 1'b0, 1'b0);
    wrAddr = 4'd5; wrData = 8'h0E;  // strobe low
    idle(); checkAll("R8 strobe low", 1'b0, 1'b0);
    wrAddr = 4'd4; wrData = 8'h77;
    idle();
    doWrite(4'd5, 8'h02);          // staged byte must still be A5
    check("R8 stage untouched", ch1Code, 12'h2A5);
    idle();
  endtask

  task automatic testBackToBack();
    doWrite(4'd4, 8'h11); checkAll("R10 b2b 1", 1'b0, 1'b0);
    doWrite(4'd5, 8'h02); check("R10 b2b ch1", ch1Code, 12'h211);
    doWrite(4'd6, 8'h33); checkAll("R10 b2b 3", 1'b0, 1'b0);
    doWrite(4'd7, 8'h04); check("R10 b2b ch2", ch2Code, 12'h433);
    doWrite(4'd4, 8'h55); checkAll("R10 R9 b2b 5", 1'b0, 1'b0);
    doWrite(4'd5, 8'h06); checkAll("R10 b2b 6", 1'b1, 1'b0);
    doWrite(4'd5, 8'h0B); checkAll("R10 R7 b2b 7", 1'b1, 1'b0);
    idle(); checkAll("R10 b2b tail", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLowThenHigh();
    testStale();
    testChannel2();
    testUnrelated();
    testBackToBack();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule